// File: doc/BRIEF.md
# Two-Stage Integer Core

This block is a 32-bit in-order processor for a small integer instruction set. The first stage only fetches. The second stage does everything else: it decodes the instruction register, reads the 32-entry register file, runs the ALU, resolves branches and jumps, accesses data memory and writes the result back. The core has one word-wide instruction port and one word-wide data port. Both ports return read data in the same cycle as the request. Stores are written at the end of the cycle in which they are presented.

Fetch always assumes the next sequential word. When a branch, jump or indirect jump resolves taken in the second stage, the program counter (PC) is loaded with the target. The word fetched behind the transfer is replaced by a no-op (NOP) in the instruction register. An 8-bit host register drives a status output, and a move-from instruction samples a host input port, so a harness can exchange values with running code.

The instruction fields sit at fixed, non-standard bit positions: rd [31:27], rs1 [26:22], rs2 [21:17], funct3 [9:7] and opcode [6:0]. The NOP is 0x00000013, which is ADDI x0,x0,0.

Top module: `duo_core`

## Requirements
- R1: While `rst` is high, the core holds PC = 0x00000000, holds NOP in the instruction register, keeps `host_out` at zero and makes no data-memory request. Fetch restarts at address 0 once `rst` falls.
- R2: Outside reset, `imem_req` is 1 and `imem_addr` steps by 4 each cycle unless a transfer is taken. The word fetched in cycle k executes in cycle k+1, and its effect is visible after the clock edge that ends cycle k+1.
- R3: Register-immediate operations use opcode 0010011 with the immediate sign-extended from [21:10]. Register-register operations use opcode 0110011. Both use the same funct3 mapping: 000 add, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 logical shift right, 110 or, 111 and. Shift amounts use the low 5 bits of the second operand. For register-register operations with funct3 000, bit 16 set selects subtract.
- R4: Opcode 0110111 writes the 20 bits [26:7] into the upper 20 bits of rd and clears the low 12 bits.
- R5: Register x0 always reads as zero, and writes to it are discarded.
- R6: Opcode 1100011 is a conditional branch, selected by funct3: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. The target is the branch's own PC plus the sign-extended 12-bit offset {[31:27],[16:10]} shifted left by one.
- R7: Opcode 1100111 jumps and opcode 1101111 jumps and links. Both go to their own PC plus sign-extended [31:7] shifted left by one. Jump-and-link also writes its own PC+4 into x1.
- R8: Opcode 1101011 jumps to rs1 plus the sign-extended [21:10] and writes its own PC+4 into rd. Its funct3 is ignored.
- R9: A taken transfer replaces the fetched word with NOP. The fetched word has no effect, `imem_addr` shows the target in the next cycle, and the target executes one cycle after that.
- R10: Load (opcode 0000011) addresses rs1 plus the [21:10] immediate and writes `dmem_rdata` into rd. Store (opcode 0100011) addresses rs1 plus the split immediate {[31:27],[16:10]} and drives rs2 on `dmem_wdata`. `dmem_we` is high only for a store, and `dmem_req` is high only for a load or store.
- R11: Opcode 1111011 is the host move instruction, with the control index at [21:17]. With funct3 001 and index 16, it loads the low 8 bits of rs1 into `host_out`; with any other index it changes nothing. With funct3 000, it writes `host_in` zero-extended into rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_req | output | 1 | Instruction fetch valid |
| imem_addr | output | 32 | Fetch address (the PC) |
| imem_rdata | input | 32 | Fetched word, same cycle |
| dmem_req | output | 1 | Data access valid |
| dmem_we | output | 1 | 1 for store, 0 for load |
| dmem_addr | output | 32 | Data byte address (word-aligned use) |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, same cycle |
| host_in | input | 8 | Value returned by the host move-from |
| host_out | output | 8 | Host status register |

## Verification
An instruction at word k of a program with no earlier taken transfer writes its register, memory or host result at the edge that ends cycle k+1 after reset release. A taken transfer shows its target on `imem_addr` one cycle after it executes. The bench samples on falling edges, at cycle counts derived from these rules: it reads `host_out` just before and just after the expected write, and it reads `imem_addr` in the cycles around a jump. For all other results it waits until the program has parked in a self-loop and then reads what was stored to data memory.

// File: rtl/duo_core.sv
module duo_core #(
  parameter int          HOST_W   = 8,
  parameter int          HOST_CR  = 16,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  output logic              imem_req,
  output logic [31:0]       imem_addr,
  input  logic [31:0]       imem_rdata,
  output logic              dmem_req,
  output logic              dmem_we,
  output logic [31:0]       dmem_addr,
  output logic [31:0]       dmem_wdata,
  input  logic [31:0]       dmem_rdata,
  input  logic [HOST_W-1:0] host_in,
  output logic [HOST_W-1:0] host_out
);
  localparam logic [31:0] NOP     = 32'h0000_0013;
  localparam logic [6:0]  OP_IMM  = 7'b0010011;
  localparam logic [6:0]  OP_REG  = 7'b0110011;
  localparam logic [6:0]  OP_LUI  = 7'b0110111;
  localparam logic [6:0]  OP_LD   = 7'b0000011;
  localparam logic [6:0]  OP_ST   = 7'b0100011;
  localparam logic [6:0]  OP_BR   = 7'b1100011;
  localparam logic [6:0]  OP_J    = 7'b1100111;
  localparam logic [6:0]  OP_JAL  = 7'b1101111;
  localparam logic [6:0]  OP_JALR = 7'b1101011;
  localparam logic [6:0]  OP_HOST = 7'b1111011;

  logic [31:0] pc, pc_x, ir;
  logic [31:0] rf [32];
  logic [HOST_W-1:0] host_q;

  wire [6:0]  opc = ir[6:0];
  wire [2:0]  f3  = ir[9:7];
  wire [4:0]  rd  = ir[31:27];
  wire [4:0]  rs1 = ir[26:22];
  wire [4:0]  rs2 = ir[21:17];
  wire [31:0] a   = (rs1 == 5'd0) ? 32'd0 : rf[rs1];
  wire [31:0] b   = (rs2 == 5'd0) ? 32'd0 : rf[rs2];
  wire [31:0] imm_i = {{20{ir[21]}}, ir[21:10]};
  wire [31:0] imm_s = {{20{ir[31]}}, ir[31:27], ir[16:10]};
  wire [31:0] imm_j = {{7{ir[31]}}, ir[31:7]};
  wire [31:0] pc4_x = pc_x + 32'd4;

  function automatic logic [31:0] alu(input logic [2:0] f, input logic sub,
                                      input logic [31:0] x, input logic [31:0] y);
    case (f)
      3'd0:    alu = sub ? x - y : x + y;
      3'd1:    alu = x << y[4:0];
      3'd2:    alu = {31'd0, $signed(x) < $signed(y)};
      3'd3:    alu = {31'd0, x < y};
      3'd4:    alu = x ^ y;
      3'd5:    alu = x >> y[4:0];
      3'd6:    alu = x | y;
      default: alu = x & y;
    endcase
  endfunction

  logic        br_take, redirect, wb_en, host_wr;
  logic [4:0]  wb_dst;
  logic [31:0] wb_val, target;

  always_comb begin
    case (f3)
      3'b000:  br_take = (a == b);
      3'b001:  br_take = (a != b);
      3'b100:  br_take = ($signed(a) < $signed(b));
      3'b101:  br_take = !($signed(a) < $signed(b));
      3'b110:  br_take = (a < b);
      3'b111:  br_take = !(a < b);
      default: br_take = 1'b0;
    endcase
  end

  always_comb begin
    wb_en = 1'b0; wb_dst = rd; wb_val = 32'd0; redirect = 1'b0;
    target = pc_x + (imm_j << 1); host_wr = 1'b0;
    dmem_req = 1'b0; dmem_we = 1'b0; dmem_addr = a + imm_i;
    case (opc)
      OP_IMM:  begin wb_en = 1'b1; wb_val = alu(f3, 1'b0, a, imm_i); end
      OP_REG:  begin wb_en = 1'b1; wb_val = alu(f3, ir[16], a, b); end
      OP_LUI:  begin wb_en = 1'b1; wb_val = {ir[26:7], 12'd0}; end
      OP_LD:   begin dmem_req = 1'b1; wb_en = 1'b1; wb_val = dmem_rdata; end
      OP_ST:   begin dmem_req = 1'b1; dmem_we = 1'b1; dmem_addr = a + imm_s; end
      OP_BR:   begin redirect = br_take; target = pc_x + (imm_s << 1); end
      OP_J:    redirect = 1'b1;
      OP_JAL:  begin redirect = 1'b1; wb_en = 1'b1; wb_dst = 5'd1; wb_val = pc4_x; end
      OP_JALR: begin redirect = 1'b1; target = a + imm_i; wb_en = 1'b1; wb_val = pc4_x; end
      OP_HOST: begin
        if (f3 == 3'b000) begin wb_en = 1'b1; wb_val = {{(32-HOST_W){1'b0}}, host_in}; end
        if (f3 == 3'b001 && rs2 == 5'(HOST_CR)) host_wr = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= RESET_PC;
      pc_x   <= RESET_PC;
      ir     <= NOP;
      host_q <= '0;
    end else begin
      pc   <= redirect ? target : pc + 32'd4;
      pc_x <= pc;
      ir   <= redirect ? NOP : imem_rdata;
      if (host_wr) host_q <= a[HOST_W-1:0];
    end
  end

  always_ff @(posedge clk)
    if (!rst && wb_en && wb_dst != 5'd0) rf[wb_dst] <= wb_val;

  assign imem_req   = !rst;
  assign imem_addr  = pc;
  assign dmem_wdata = b;
  assign host_out   = host_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (imem_addr == RESET_PC && ir == NOP && host_out == '0));

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(redirect)) |-> imem_addr == $past(imem_addr) + 32'd4);

  assert_kill_slot_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(redirect)) |-> (ir == NOP && imem_addr == $past(target)));

  assert_store_is_req_R10: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> dmem_req);

  assert_host_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(host_wr)) |-> host_out == $past(host_out));
endmodule

// File: tb/duo_core_tb_top.sv
module duo_core_tb_top;
  localparam logic [6:0] OP_IMM = 7'b0010011, OP_REG = 7'b0110011, OP_LUI = 7'b0110111,
                         OP_LD = 7'b0000011, OP_ST = 7'b0100011, OP_BR = 7'b1100011,
                         OP_J = 7'b1100111, OP_JAL = 7'b1101111, OP_JALR = 7'b1101011,
                         OP_HOST = 7'b1111011;

  logic        clk = 1'b0, rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        imem_req, dmem_req, dmem_we;
  logic [7:0]  host_in = 8'h00, host_out;
  logic [31:0] imem [0:255];
  logic [31:0] dmem [0:255];
  int n_run = 0, n_fail = 0, pp = 0;

  always #4 clk = ~clk;

  duo_core dut_i (
    .clk(clk), .rst(rst), .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata), .host_in(host_in), .host_out(host_out)
  );

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_req && dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [4:0] rs2, input logic [4:0] rs1,
                                      input logic [2:0] f3, input logic [4:0] rd);
    return {rd, rs1, rs2, f7, f3, OP_REG};
  endfunction
  function automatic logic [31:0] e_i(input logic [11:0] imm, input logic [4:0] rs1, input logic [2:0] f3,
                                      input logic [4:0] rd, input logic [6:0] op);
    return {rd, rs1, imm, f3, op};
  endfunction
  function automatic logic [31:0] e_b(input logic [11:0] imm, input logic [4:0] rs1, input logic [4:0] rs2,
                                      input logic [2:0] f3, input logic [6:0] op);
    return {imm[11:7], rs1, rs2, imm[6:0], f3, op};
  endfunction
  function automatic logic [31:0] e_host(input logic [4:0] rd, input logic [4:0] rs1,
                                         input logic [4:0] cr, input logic [2:0] f3);
    return {rd, rs1, cr, 7'd0, f3, OP_HOST};
  endfunction

  function automatic logic [31:0] ref_alu(input logic [2:0] f, input logic sub,
                                          input logic [31:0] x, input logic [31:0] y);
    case (f)
      3'd0: return sub ? x - y : x + y;
      3'd1: return x << y[4:0];
      3'd2: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      3'd3: return (x < y) ? 32'd1 : 32'd0;
      3'd4: return x ^ y;
      3'd5: return x >> y[4:0];
      3'd6: return x | y;
      default: return x & y;
    endcase
  endfunction
  function automatic logic ref_br(input logic [2:0] f, input logic [31:0] x, input logic [31:0] y);
    case (f)
      3'b000: return x == y;
      3'b001: return x != y;
      3'b100: return $signed(x) < $signed(y);
      3'b101: return $signed(x) >= $signed(y);
      3'b110: return x < y;
      default: return x >= y;
    endcase
  endfunction

  task automatic emit(input logic [31:0] w);
    imem[pp] = w;
    pp++;
  endtask
  task automatic ld(input logic [4:0] rd, input logic [31:0] v);
    logic [31:0] hi;
    hi = (v + 32'h800) >> 12;
    emit({rd, hi[19:0], OP_LUI});
    emit(e_i(v[11:0], rd, 3'd0, rd, OP_IMM));
  endtask
  task automatic prog_begin();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      imem[i] = {25'd0, OP_J};
      dmem[i] = 32'd0;
    end
    pp = 0;
  endtask
  task automatic go(input int n);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));

    // R4: upper immediate; R5: write to x0 discarded
    prog_begin();
    emit({5'd3, 20'hABCDE, OP_LUI});
    emit(e_i(12'h055, 5'd0, 3'd0, 5'd0, OP_IMM));
    emit(e_b(12'h200, 5'd0, 5'd3, 3'b010, OP_ST));
    emit(e_b(12'h204, 5'd0, 5'd0, 3'b010, OP_ST));
    go(10);
    chk("R4 lui", dmem[128], 32'hABCDE000);
    chk("R5 x0", dmem[129], 32'd0);

    // R3: random ALU operations, register and immediate forms
    for (int it = 0; it < 40; it++) begin
      logic [31:0] x, y, exp;
      logic [2:0] f;
      logic sub, use_imm;
      logic [11:0] imm;
      x = $urandom; y = $urandom; f = 3'($urandom % 8);
      use_imm = it[0]; sub = !use_imm && f == 3'd0 && ($urandom % 2 == 1);
      imm = 12'($urandom);
      if (it == 2) x = 32'h8000_0000;
      if (it == 3) y = x;
      prog_begin();
      ld(5'd1, x); ld(5'd2, y);
      if (use_imm) begin
        emit(e_i(imm, 5'd1, f, 5'd3, OP_IMM));
        exp = ref_alu(f, 1'b0, x, {{20{imm[11]}}, imm});
      end else begin
        emit(e_r(sub ? 7'b1000000 : 7'd0, 5'd2, 5'd1, f, 5'd3));
        exp = ref_alu(f, sub, x, y);
      end
      emit(e_b(12'h200, 5'd0, 5'd3, 3'b010, OP_ST));
      go(10);
      chk(use_imm ? "R3 alu imm" : "R3 alu reg", dmem[128], exp);
    end

    // R6 + R9: each branch condition, fall-through killed when taken
    for (int k = 0; k < 6; k++) begin
      for (int pr = 0; pr < 5; pr++) begin
        logic [2:0] f;
        logic [31:0] x, y;
        case (k) 0: f = 3'b000; 1: f = 3'b001; 2: f = 3'b100; 3: f = 3'b101; 4: f = 3'b110; default: f = 3'b111; endcase
        case (pr)
          0: begin x = 32'd5; y = 32'd5; end
          1: begin x = 32'd3; y = 32'd9; end
          2: begin x = 32'hFFFF_FFF0; y = 32'd4; end
          3: begin x = 32'd4; y = 32'hFFFF_FFF0; end
          default: begin x = $urandom; y = $urandom; end
        endcase
        prog_begin();
        ld(5'd1, x); ld(5'd2, y);
        emit(e_i(12'd3, 5'd0, 3'd0, 5'd5, OP_IMM));
        emit(e_b(12'd4, 5'd1, 5'd2, f, OP_BR));
        emit(e_i(12'd7, 5'd0, 3'd0, 5'd5, OP_IMM));
        emit(e_b(12'h200, 5'd0, 5'd5, 3'b010, OP_ST));
        go(14);
        chk("R6 R9 branch", dmem[128], ref_br(f, x, y) ? 32'd3 : 32'd7);
      end
    end

    // R6: backward branch loop counts to 4
    prog_begin();
    emit(e_i(12'd4, 5'd0, 3'd0, 5'd6, OP_IMM));
    emit(e_i(12'd0, 5'd0, 3'd0, 5'd5, OP_IMM));
    emit(e_i(12'd1, 5'd5, 3'd0, 5'd5, OP_IMM));
    emit(e_b(12'hFFE, 5'd5, 5'd6, 3'b001, OP_BR));
    emit(e_b(12'h200, 5'd0, 5'd5, 3'b010, OP_ST));
    go(30);
    chk("R6 backward loop", dmem[128], 32'd4);

    // R7 + R9: J and JAL, with redirect timing on imem_addr
    for (int v = 0; v < 2; v++) begin
      logic [31:0] a3, a4;
      prog_begin();
      emit(e_i(12'd3, 5'd0, 3'd0, 5'd5, OP_IMM));
      emit(e_i(12'h077, 5'd0, 3'd0, 5'd1, OP_IMM));
      emit({25'd6, (v == 1) ? OP_JAL : OP_J});
      emit(e_i(12'd7, 5'd0, 3'd0, 5'd5, OP_IMM));
      emit(e_i(12'd7, 5'd0, 3'd0, 5'd5, OP_IMM));
      emit(e_b(12'h200, 5'd0, 5'd1, 3'b010, OP_ST));
      emit(e_b(12'h204, 5'd0, 5'd5, 3'b010, OP_ST));
      go(3); a3 = imem_addr;
      go(1); a4 = imem_addr;
      go(10);
      chk("R9 fetch before redirect", a3, 32'd12);
      chk("R9 redirect to target", a4, 32'd20);
      chk("R7 link", dmem[128], (v == 1) ? 32'd12 : 32'h77);
      chk("R7 skipped slots", dmem[129], 32'd3);
    end

    // R8: indirect jump with link
    prog_begin();
    emit(e_i(12'd3, 5'd0, 3'd0, 5'd5, OP_IMM));
    emit(e_i(12'd16, 5'd0, 3'd0, 5'd2, OP_IMM));
    emit(e_i(12'd8, 5'd2, 3'b010, 5'd6, OP_JALR));
    emit(e_i(12'd7, 5'd0, 3'd0, 5'd5, OP_IMM));
    emit(e_i(12'd7, 5'd0, 3'd0, 5'd5, OP_IMM));
    emit(e_i(12'd7, 5'd0, 3'd0, 5'd5, OP_IMM));
    emit(e_b(12'h200, 5'd0, 5'd6, 3'b010, OP_ST));
    emit(e_b(12'h204, 5'd0, 5'd5, 3'b010, OP_ST));
    go(14);
    chk("R8 jalr link", dmem[128], 32'd12);
    chk("R8 jalr target", dmem[129], 32'd3);

    // R10: load, immediate use, store with negative offset
    begin
      logic [31:0] v;
      v = $urandom;
      prog_begin();
      dmem[16] = v;
      emit(e_i(12'h03C, 5'd0, 3'd0, 5'd2, OP_IMM));
      emit(e_i(12'd4, 5'd2, 3'b010, 5'd3, OP_LD));
      emit(e_i(12'd1, 5'd3, 3'd0, 5'd4, OP_IMM));
      emit(e_b(12'hFFC, 5'd2, 5'd4, 3'b010, OP_ST));
      go(10);
      chk("R10 load-store", dmem[14], v + 32'd1);
      chk("R10 load untouched", dmem[16], v);
    end

    // R2 + R11: host writes, ignored index, host read; then R1 reset
    begin
      logic [7:0] h;
      logic [31:0] ad0, ad1, ad2, hs2, hs3, rq0;
      h = 8'($urandom) | 8'h01;
      host_in = h;
      prog_begin();
      emit(e_i(12'h1A5, 5'd0, 3'd0, 5'd1, OP_IMM));
      emit(e_host(5'd0, 5'd1, 5'd16, 3'b001));
      emit(e_i(12'h03C, 5'd0, 3'd0, 5'd2, OP_IMM));
      emit(e_host(5'd0, 5'd2, 5'd5, 3'b001));
      emit(e_host(5'd3, 5'd0, 5'd0, 3'b000));
      emit(e_b(12'h200, 5'd0, 5'd3, 3'b010, OP_ST));
      rq0 = {31'd0, dmem_req};
      ad0 = imem_addr;
      go(1); ad1 = imem_addr;
      go(1); ad2 = imem_addr; hs2 = {24'd0, host_out};
      go(1); hs3 = {24'd0, host_out};
      go(8);
      chk("R1 fetch starts at 0", ad0, 32'd0);
      chk("R1 no data request in reset", rq0, 32'd0);
      chk("R2 fetch step", ad1, 32'd4);
      chk("R2 fetch step 2", ad2, 32'd8);
      chk("R2 host not yet", hs2, 32'd0);
      chk("R2 R11 host written", hs3, 32'hA5);
      chk("R11 other index ignored", {24'd0, host_out}, 32'hA5);
      chk("R11 host read", dmem[128], {24'd0, h});
      chk("R2 fetch valid", {31'd0, imem_req}, 32'd1);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 host cleared", {24'd0, host_out}, 32'd0);
      chk("R1 pc cleared", imem_addr, 32'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule